// File: doc/BRIEF.md
# Header Look-up Microsequencer

This block is a small sequencer that classifies one stored packet header at a time by walking a decision program. The program lives in an external SRAM. Each instruction word is 36 bits wide, so the spare parity bits carry argument data. For every header the walk starts again at program address 0. Each step fetches a word, decodes it and runs one of three instruction kinds.

A CAM instruction streams a chosen set of header registers to an external CAM, one register per cycle. It then waits for the CAM's match address and continues from that SRAM word. A branch instruction masks one header register, compares it against a constant and moves forward by a power-of-two step when the test succeeds. An EXE instruction ends the walk. It pushes a result word and the packet identifier to the output queue and releases the header buffer entry.

The header buffer is a register file with a combinational read port. The SRAM has a request/valid read port with any latency. The CAM has a load stream and a result strobe. The output queue accepts one word per valid pulse.

Top module: `hdr_lookup_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, sram_req, cam_wr_valid, out_valid and hdr_release are all low.
- R2: When hdr_valid is seen in the idle state, the first fetch of the walk is to SRAM address 0, and hdr_pid is kept for that walk.
- R3: The opcode sits in bits [35:33]. The codes are 0 CAM, 1 branch-if-equal, 2 branch-if-not-equal, 3 branch-if-less-or-equal, 4 branch-if-greater and 7 EXE. Codes 5 and 6 are undefined.
- R4: A branch reads the header register whose index is in bits [32:28]. It ANDs the register with the mask in bits [23:12] and compares the result, unsigned, against the constant in bits [11:0], using the test its opcode selects.
- R5: After a branch that succeeds, the next fetch address is PC+1+2^k, where k is the step code in bits [27:25]. After a branch that fails, it is PC+1. Addresses wrap modulo 2^PC_W.
- R6: A CAM instruction takes a register bitmap from bits [31:0]. It sends the contents of each selected register on cam_wr_data, one per cycle, in ascending index order. cam_wr_last is high on the final one only.
- R7: After the last CAM load, no further load and no fetch happen until cam_res_valid. The next fetch is then to cam_res_addr.
- R8: EXE raises out_valid for one cycle, with out_result set to bits [15:0] and out_pid set to the walk's identifier. hdr_release is high in the same cycle.
- R9: An undefined opcode, or a CAM instruction with an empty bitmap, ends the walk with out_result equal to the software-path code 0xFFFF.
- R10: If another header is waiting when one is released, the next walk starts without any extra request, again at address 0.
- R11: Each fetch raises sram_req for exactly one cycle. The block then holds until sram_rvalid, whatever the SRAM latency, and issues no new request in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | A complete header is waiting in the buffer |
| hdr_pid | input | PID_W | Identifier of the waiting packet |
| hdr_release | output | 1 | Pulse that frees the buffer entry |
| hdr_raddr | output | $clog2(NREG) | Header register read index |
| hdr_rdata | input | REG_W | Header register contents, combinational |
| sram_req | output | 1 | Instruction fetch request |
| sram_addr | output | PC_W | Fetch address |
| sram_rvalid | input | 1 | Fetched word valid |
| sram_rdata | input | INSTR_W | Fetched instruction word |
| cam_wr_valid | output | 1 | CAM load beat valid |
| cam_wr_data | output | REG_W | Register contents for the CAM key |
| cam_wr_last | output | 1 | Final beat of the key |
| cam_res_valid | input | 1 | CAM match address valid |
| cam_res_addr | input | PC_W | SRAM address of the matched entry |
| out_valid | output | 1 | Result push to the output queue |
| out_result | output | RES_W | Result argument |
| out_pid | output | PID_W | Packet identifier of the result |

## Verification
The assertions rely on the neighbours following the protocol. sram_rvalid comes back once for each request. cam_res_valid comes only after a completed CAM key. hdr_valid reflects the buffer state in the cycle after a release. The bench models these neighbours so that they stay within those rules: one pending SRAM read with a random latency of 0 to 2 cycles, and one pending CAM reply with a latency of 0 to 3 cycles. Random programs use only forward branches in a lower region, and CAM jumps land in an upper region of terminating words, so every walk ends and the fetch trace can be predicted exactly.

// File: rtl/hls_pkg.sv
package hls_pkg;
   localparam logic [2:0] OPC_CAM = 3'd0;
   localparam logic [2:0] OPC_BEQ = 3'd1;
   localparam logic [2:0] OPC_BNE = 3'd2;
   localparam logic [2:0] OPC_BLE = 3'd3;
   localparam logic [2:0] OPC_BGT = 3'd4;
   localparam logic [2:0] OPC_EXE = 3'd7;

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_WAIT, S_DEC, S_CAMLD, S_CAMWAIT
   } seq_state_e;

   typedef enum logic [1:0] {
      K_CAM, K_BRANCH, K_EXE, K_BAD
   } instr_kind_e;
endpackage

// File: rtl/hls_list_scan.sv
module hls_list_scan #(
   parameter int NREG      = 32,
   parameter int LSB_FIRST = 1,
   localparam int AW       = $clog2(NREG)
) (
   input  logic [NREG-1:0] list,
   output logic [AW-1:0]   idx,
   output logic [NREG-1:0] rest
);
   generate
      if (LSB_FIRST != 0) begin : g_low_first
         always_comb begin
            logic hit;
            hit = 1'b0;
            idx = '0;
            for (int i = 0; i < NREG; i++) begin
               if (!hit && list[i]) begin
                  idx = AW'(i);
                  hit = 1'b1;
               end
            end
         end
      end else begin : g_high_first
         always_comb begin
            logic hit;
            hit = 1'b0;
            idx = '0;
            for (int i = NREG - 1; i >= 0; i--) begin
               if (!hit && list[i]) begin
                  idx = AW'(i);
                  hit = 1'b1;
               end
            end
         end
      end
   endgenerate

   assign rest = list & ~({{(NREG-1){1'b0}}, 1'b1} << idx);
endmodule

// File: rtl/hls_branch_unit.sv
module hls_branch_unit #(
   parameter int REG_W = 12,
   parameter int PC_W  = 10
) (
   input  logic [2:0]       opc,
   input  logic [2:0]       step_code,
   input  logic [PC_W-1:0]  pc,
   input  logic [REG_W-1:0] reg_val,
   input  logic [REG_W-1:0] mask,
   input  logic [REG_W-1:0] cval,
   output logic             taken,
   output logic [PC_W-1:0]  next_pc
);
   import hls_pkg::*;

   logic [PC_W-1:0]  offs [8];
   logic [PC_W-1:0]  pc_seq;
   logic [PC_W-1:0]  pc_jmp;
   logic [REG_W-1:0] masked;

   generate
      for (genvar k = 0; k < 8; k++) begin : g_offs
         assign offs[k] = PC_W'(1) << k;
      end
   endgenerate

   // both targets are formed alongside the compare
   assign pc_seq = pc + PC_W'(1);
   assign pc_jmp = pc_seq + offs[step_code];
   assign masked = reg_val & mask;

   always_comb begin
      case (opc)
         OPC_BEQ: taken = (masked == cval);
         OPC_BNE: taken = (masked != cval);
         OPC_BLE: taken = (masked <= cval);
         OPC_BGT: taken = (masked >  cval);
         default: taken = 1'b0;
      endcase
   end

   assign next_pc = taken ? pc_jmp : pc_seq;
endmodule

// File: rtl/hdr_lookup_seq.sv
module hdr_lookup_seq #(
   parameter int          NREG      = 32,
   parameter int          REG_W     = 12,
   parameter int          PC_W      = 10,
   parameter int          INSTR_W   = 36,
   parameter int          RES_W     = 16,
   parameter int          PID_W     = 8,
   parameter int          LSB_FIRST = 1,
   parameter int unsigned SW_RESULT = 32'h0000_FFFF,
   localparam int         AW        = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hdr_valid,
   input  logic [PID_W-1:0]   hdr_pid,
   output logic               hdr_release,
   output logic [AW-1:0]      hdr_raddr,
   input  logic [REG_W-1:0]   hdr_rdata,
   output logic               sram_req,
   output logic [PC_W-1:0]    sram_addr,
   input  logic               sram_rvalid,
   input  logic [INSTR_W-1:0] sram_rdata,
   output logic               cam_wr_valid,
   output logic [REG_W-1:0]   cam_wr_data,
   output logic               cam_wr_last,
   input  logic               cam_res_valid,
   input  logic [PC_W-1:0]    cam_res_addr,
   output logic               out_valid,
   output logic [RES_W-1:0]   out_result,
   output logic [PID_W-1:0]   out_pid
);
   import hls_pkg::*;

   localparam int OP_LSB   = INSTR_W - 3;
   localparam int ADDR_LSB = OP_LSB - AW;
   localparam int STEP_LSB = ADDR_LSB - 3;
   localparam logic [RES_W-1:0] SW_CODE = RES_W'(SW_RESULT);

   generate
      if (2 * REG_W > STEP_LSB) begin : g_chk_fields
         $error("mask and constant fields do not fit the instruction word");
      end
      if (NREG > OP_LSB || RES_W > OP_LSB) begin : g_chk_list
         $error("register bitmap or result field overlaps the opcode");
      end
      if (PC_W < 8) begin : g_chk_pc
         $error("program counter too narrow for the largest step");
      end
      if (STEP_LSB > 2 * REG_W) begin : g_spare
         logic unused_spare;
         assign unused_spare = ^ir[STEP_LSB-1:2*REG_W];
      end
   endgenerate

   seq_state_e          state;
   logic [PC_W-1:0]     pc;
   logic [INSTR_W-1:0]  ir;
   logic [PID_W-1:0]    pid_q;
   logic [NREG-1:0]     list_q;

   logic [2:0]          ir_opc;
   logic [AW-1:0]       ir_addr;
   logic [2:0]          ir_step;
   logic [REG_W-1:0]    ir_mask;
   logic [REG_W-1:0]    ir_cval;
   logic [NREG-1:0]     ir_list;
   instr_kind_e         kind;

   logic                start;
   logic                br_taken;
   logic [PC_W-1:0]     br_next;
   logic [AW-1:0]       scan_idx;
   logic [NREG-1:0]     scan_rest;

   assign ir_opc  = ir[INSTR_W-1:OP_LSB];
   assign ir_addr = ir[OP_LSB-1:ADDR_LSB];
   assign ir_step = ir[ADDR_LSB-1:STEP_LSB];
   assign ir_mask = ir[2*REG_W-1:REG_W];
   assign ir_cval = ir[REG_W-1:0];
   assign ir_list = ir[NREG-1:0];

   always_comb begin
      case (ir_opc)
         OPC_CAM:                            kind = K_CAM;
         OPC_BEQ, OPC_BNE, OPC_BLE, OPC_BGT: kind = K_BRANCH;
         OPC_EXE:                            kind = K_EXE;
         default:                            kind = K_BAD;
      endcase
   end

   // a release pulse means hdr_valid still describes the header just freed
   assign start = hdr_valid && !hdr_release;

   hls_branch_unit #(.REG_W(REG_W), .PC_W(PC_W)) u_branch (
      .opc       (ir_opc),
      .step_code (ir_step),
      .pc        (pc),
      .reg_val   (hdr_rdata),
      .mask      (ir_mask),
      .cval      (ir_cval),
      .taken     (br_taken),
      .next_pc   (br_next)
   );

   hls_list_scan #(.NREG(NREG), .LSB_FIRST(LSB_FIRST)) u_scan (
      .list (list_q),
      .idx  (scan_idx),
      .rest (scan_rest)
   );

   assign hdr_raddr    = (state == S_CAMLD) ? scan_idx : ir_addr;
   assign sram_req     = (state == S_FETCH);
   assign sram_addr    = pc;
   assign cam_wr_valid = (state == S_CAMLD);
   assign cam_wr_data  = hdr_rdata;
   assign cam_wr_last  = (state == S_CAMLD) && (scan_rest == '0);

   logic             fin_now;
   logic [RES_W-1:0] fin_res;

   always_comb begin
      fin_now = 1'b0;
      fin_res = SW_CODE;
      if (state == S_DEC) begin
         case (kind)
            K_EXE:    begin fin_now = 1'b1; fin_res = ir[RES_W-1:0]; end
            K_BAD:    fin_now = 1'b1;
            K_CAM:    fin_now = (ir_list == '0);
            default:  fin_now = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         pc          <= '0;
         ir          <= '0;
         pid_q       <= '0;
         list_q      <= '0;
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_pid     <= '0;
         hdr_release <= 1'b0;
      end else begin
         out_valid   <= 1'b0;
         hdr_release <= 1'b0;
         if (fin_now) begin
            out_valid   <= 1'b1;
            out_result  <= fin_res;
            out_pid     <= pid_q;
            hdr_release <= 1'b1;
            state       <= S_IDLE;
         end else begin
            case (state)
               S_IDLE: if (start) begin
                  pid_q <= hdr_pid;
                  pc    <= '0;
                  state <= S_FETCH;
               end
               S_FETCH: state <= S_WAIT;
               S_WAIT: if (sram_rvalid) begin
                  ir    <= sram_rdata;
                  state <= S_DEC;
               end
               S_DEC: begin
                  if (kind == K_CAM) begin
                     list_q <= ir_list;
                     state  <= S_CAMLD;
                  end else begin
                     pc    <= br_next;
                     state <= S_FETCH;
                  end
               end
               S_CAMLD: begin
                  list_q <= scan_rest;
                  if (scan_rest == '0) state <= S_CAMWAIT;
               end
               S_CAMWAIT: if (cam_res_valid) begin
                  pc    <= cam_res_addr;
                  state <= S_FETCH;
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end

   // R1: quiet interface right after reset
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!sram_req && !cam_wr_valid && !out_valid && !hdr_release));

   // R2: a new walk opens with a fetch of address 0
   assert_start_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && start) |=> (sram_req && sram_addr == '0));

   // R6: each beat streams a register selected by the bitmap
   assert_scan_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cam_wr_valid |-> list_q[hdr_raddr]);

   // R6: the last flag only rides on a valid beat
   assert_last_on_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cam_wr_last |-> cam_wr_valid);

   // R7: after the key is complete, nothing moves until the CAM answers
   assert_cam_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cam_wr_last |=> (!cam_wr_valid && !sram_req));

   // R8: a single result push per walk, with the release beside it
   assert_one_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> (!out_valid && !sram_req));

   // R11: fetch request lasts one cycle
   assert_fetch_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sram_req |=> !sram_req);
endmodule

// File: tb/hdr_lookup_seq_tb.sv
module hdr_lookup_seq_tb;
   localparam int NREG = 32, REG_W = 12, PC_W = 10, INSTR_W = 36, RES_W = 16, PID_W = 8;
   localparam int DEPTH = 1 << PC_W;
   localparam logic [15:0] SW = 16'hFFFF;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               hdr_valid = 1'b0;
   logic [PID_W-1:0]   hdr_pid = '0;
   logic               hdr_release;
   logic [4:0]         hdr_raddr;
   logic [REG_W-1:0]   hdr_rdata;
   logic               sram_req;
   logic [PC_W-1:0]    sram_addr;
   logic               sram_rvalid = 1'b0;
   logic [INSTR_W-1:0] sram_rdata = '0;
   logic               cam_wr_valid;
   logic [REG_W-1:0]   cam_wr_data;
   logic               cam_wr_last;
   logic               cam_res_valid = 1'b0;
   logic [PC_W-1:0]    cam_res_addr = '0;
   logic               out_valid;
   logic [RES_W-1:0]   out_result;
   logic [PID_W-1:0]   out_pid;

   always #5 clk = ~clk;

   hdr_lookup_seq u_dut (.*);

   logic [INSTR_W-1:0] mem [DEPTH];
   logic [REG_W-1:0]   hregs [NREG];
   logic [PC_W-1:0]    cam_target = '0;
   assign hdr_rdata = hregs[hdr_raddr];

   int checks = 0, errors = 0, cycles = 0;

   // observed traces
   int               got_fn, got_cn, last_bad, rel_bad, overlap_bad;
   int               got_f [512];
   logic [REG_W-1:0] got_c [1024];
   logic             got_out;
   logic [15:0]      got_res;
   logic [7:0]       got_pid;
   // expected traces
   int               exp_fn, exp_cn;
   int               exp_f [512];
   logic [REG_W-1:0] exp_c [1024];

   logic       sr_pend = 1'b0, cm_pend = 1'b0;
   int         sr_lat, cm_lat;
   logic [PC_W-1:0] sr_addr;

   always @(negedge clk) begin
      cycles++;
      sram_rvalid   = 1'b0;
      cam_res_valid = 1'b0;
      if (sr_pend) begin
         if (sr_lat == 0) begin
            sram_rvalid = 1'b1; sram_rdata = mem[sr_addr]; sr_pend = 1'b0;
         end else sr_lat--;
      end
      if (cm_pend) begin
         if (cm_lat == 0) begin
            cam_res_valid = 1'b1; cam_res_addr = cam_target; cm_pend = 1'b0;
         end else cm_lat--;
      end
      if (sram_req) begin
         if (sr_pend || cm_pend) overlap_bad++;
         sr_pend = 1'b1; sr_addr = sram_addr; sr_lat = int'($urandom % 3);
         if (got_fn < 512) got_f[got_fn] = int'(sram_addr);
         got_fn++;
      end
      if (cam_wr_valid) begin
         if (sr_pend || cm_pend) overlap_bad++;
         if (got_cn < 1024) got_c[got_cn] = cam_wr_data;
         got_cn++;
         if (cam_wr_last) begin
            cm_pend = 1'b1; cm_lat = int'($urandom % 4);
         end
      end
      if (cam_wr_last && !cam_wr_valid) last_bad++;
      if (out_valid !== hdr_release) rel_bad++;
      if (out_valid) begin
         got_out = 1'b1; got_res = out_result; got_pid = out_pid;
      end
   end

   always @(posedge clk) if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [35:0] f_br(input int op, input int a, input int st,
                                        input int m, input int c);
      return {3'(op), 5'(a), 3'(st), 1'b0, 12'(m), 12'(c)};
   endfunction
   function automatic logic [35:0] f_cam(input logic [31:0] l);
      return {3'd0, 1'b0, l};
   endfunction
   function automatic logic [35:0] f_exe(input int r);
      return {3'd7, 17'd0, 16'(r)};
   endfunction

   // reference walk from the requirements
   task automatic model_run(output logic [15:0] res);
      int pc = 0;
      bit done = 0;
      exp_fn = 0; exp_cn = 0; res = SW;
      for (int it = 0; it < 400 && !done; it++) begin
         logic [35:0] w;
         w = mem[pc];
         exp_f[exp_fn] = pc; exp_fn++;
         case (w[35:33])
            3'd0: begin
               if (w[31:0] == 0) begin res = SW; done = 1; end
               else begin
                  for (int i = 0; i < NREG; i++)
                     if (w[i]) begin exp_c[exp_cn] = hregs[i]; exp_cn++; end
                  pc = int'(cam_target);
               end
            end
            3'd1, 3'd2, 3'd3, 3'd4: begin
               logic [11:0] m, c;
               bit tk;
               m = hregs[w[32:28]] & w[23:12];
               c = w[11:0];
               case (w[35:33])
                  3'd1: tk = (m == c);
                  3'd2: tk = (m != c);
                  3'd3: tk = (m <= c);
                  default: tk = (m > c);
               endcase
               pc = (pc + 1 + (tk ? (1 << w[27:25]) : 0)) % DEPTH;
            end
            3'd7: begin res = w[15:0]; done = 1; end
            default: begin res = SW; done = 1; end
         endcase
      end
   endtask

   task automatic run_hdr(input logic [7:0] pid, input bit keep, input string req);
      logic [15:0] er;
      int n, mis;
      model_run(er);
      got_fn = 0; got_cn = 0; got_out = 1'b0;
      last_bad = 0; rel_bad = 0; overlap_bad = 0;
      hdr_pid = pid; hdr_valid = 1'b1;
      n = 0;
      while (!got_out && n < 4000) begin
         @(negedge clk); #1;
         n++;
      end
      if (!keep) hdr_valid = 1'b0;
      chk(got_out, {req, " walk completes"}, longint'(got_out), 1);
      chk(got_res == er, {req, " out_result"}, got_res, er);
      chk(got_pid == pid, "R8 out_pid", got_pid, pid);
      chk(got_fn > 0 && got_f[0] == 0, "R2 first fetch at 0", got_f[0], 0);
      mis = (got_fn != exp_fn) ? 1 : 0;
      for (int i = 0; i < exp_fn && i < 512; i++) if (got_f[i] != exp_f[i]) mis++;
      chk(mis == 0, "R5 fetch trace", got_fn, exp_fn);
      mis = (got_cn != exp_cn) ? 1 : 0;
      for (int i = 0; i < exp_cn && i < 1024; i++) if (got_c[i] != exp_c[i]) mis++;
      chk(mis == 0 && last_bad == 0, "R6 CAM key stream", got_cn, exp_cn);
      chk(overlap_bad == 0, "R11 one outstanding access", overlap_bad, 0);
      chk(rel_bad == 0, "R8 release with result", rel_bad, 0);
   endtask

   task automatic rand_regs();
      for (int i = 0; i < NREG; i++) hregs[i] = 12'($urandom);
   endtask

   task automatic fill_background();
      for (int a = 0; a < DEPTH; a++) mem[a] = f_exe(a);
   endtask

   task automatic rand_program();
      fill_background();
      for (int a = 0; a < 256; a++) begin
         int r;
         r = int'($urandom % 16);
         if (r < 9)
            mem[a] = f_br(1 + int'($urandom % 4), int'($urandom % 32), int'($urandom % 8),
                          int'($urandom), int'($urandom % 8));
         else if (r < 11) mem[a] = f_cam($urandom & $urandom & $urandom);
         else if (r < 14) mem[a] = f_exe(int'($urandom));
         else if (r < 15) mem[a] = {3'(5 + $urandom % 2), 33'($urandom)};
         else mem[a] = f_cam(32'd0);
      end
   endtask

   initial begin
      void'($urandom(32'd20417));
      for (int i = 0; i < NREG; i++) hregs[i] = 12'(i * 37);
      fill_background();
      repeat (3) @(negedge clk);
      #1;
      chk(!sram_req && !cam_wr_valid && !out_valid && !hdr_release, "R1 quiet in reset",
          {sram_req, cam_wr_valid, out_valid, hdr_release}, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!sram_req && !out_valid && !hdr_release, "R1 quiet after reset",
          {sram_req, out_valid, hdr_release}, 0);

      // R4 equal test taken, R5 largest step
      mem[0] = f_br(1, 3, 7, 12'hFFF, int'(hregs[3]));
      run_hdr(8'h11, 0, "R5");
      chk(got_res == 16'd129, "R5 step 128 target", got_res, 129);

      // R4 less-or-equal at the boundary (taken, step 1)
      fill_background();
      mem[0] = f_br(3, 5, 0, 12'hF0F, int'(hregs[5] & 12'hF0F));
      run_hdr(8'h12, 0, "R4");
      chk(got_res == 16'd2, "R4 LE equal taken", got_res, 2);

      // R4 greater-than at the boundary (not taken)
      mem[0] = f_br(4, 5, 2, 12'hF0F, int'(hregs[5] & 12'hF0F));
      run_hdr(8'h13, 0, "R4");
      chk(got_res == 16'd1, "R4 GT equal not taken", got_res, 1);

      // R4 not-equal with mask zero never succeeds against constant 0
      mem[0] = f_br(2, 9, 3, 0, 0);
      run_hdr(8'h14, 0, "R4");
      chk(got_res == 16'd1, "R4 NE masked off", got_res, 1);

      // R9 undefined opcodes and empty bitmap
      mem[0] = {3'd6, 33'h1_2345_6789};
      run_hdr(8'h15, 0, "R9");
      chk(got_res == SW, "R9 opcode 6", got_res, SW);
      mem[0] = {3'd5, 33'd0};
      run_hdr(8'h16, 0, "R9");
      chk(got_res == SW, "R9 opcode 5", got_res, SW);
      mem[0] = f_cam(32'd0);
      run_hdr(8'h17, 0, "R9");
      chk(got_res == SW, "R9 empty CAM list", got_res, SW);

      // R6 extremes of the bitmap, R7 jump to the CAM answer
      mem[0] = f_cam(32'h8000_0081);
      cam_target = 10'd300;
      mem[300] = f_exe(16'h5A5A);
      run_hdr(8'h18, 0, "R7");
      chk(got_cn == 3 && got_c[0] == hregs[0] && got_c[2] == hregs[31],
          "R6 ascending order", got_cn, 3);

      // R5 wrap of the program counter
      mem[0] = f_cam(32'h0000_0001);
      cam_target = 10'd1023;
      mem[1023] = f_br(1, 0, 0, 0, 0);
      mem[1] = f_exe(16'h0ABC);
      run_hdr(8'h19, 0, "R5");
      chk(got_res == 16'h0ABC, "R5 wrap to address 1", got_res, 16'h0ABC);

      // R10 back-to-back headers
      fill_background();
      mem[0] = f_br(1, 1, 4, 12'hFFF, int'(hregs[1]));
      run_hdr(8'h21, 1, "R10");
      hregs[1] = hregs[1] ^ 12'h001;
      run_hdr(8'h22, 0, "R10");
      chk(got_res == 16'd1 && got_pid == 8'h22, "R10 second walk", got_res, 1);

      // random programs and headers
      for (int p = 0; p < 8; p++) begin
         rand_program();
         for (int h = 0; h < 20; h++) begin
            rand_regs();
            cam_target = PC_W'(256 + $urandom % 700);
            run_hdr(8'($urandom), bit'($urandom % 2), "R3");
         end
      end
      hdr_valid = 1'b0;
      repeat (4) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule